// File: doc/BRIEF.md
# Flash Cycle Launch Control Register

This block is the software-facing control point for hardware-sequenced serial flash cycles. Software writes one 16-bit control word that holds the cycle kind, a zero-based byte count, an interrupt enable and a launch bit. Setting the launch bit raises a request toward a flash bus arbiter. The launch bit clears itself when the arbiter grants the cycle. From that point the block presents a stable cycle kind and byte count to the downstream serial engine until the engine reports completion.

Completion sets a sticky done flag. This flag sits in a separate 16-bit status word, and software clears it by writing a 1 to it. While the done flag and the interrupt enable are both set, an interrupt request output is raised. The control word rejects every write from the launch until software clears the done flag. This keeps a cycle's parameters from being changed while it is in flight. Software may put the kind, count and enable in the same write that sets the launch bit.

Top module: `flash_seq_ctl`

## Requirements
- R1: After reset the control word reads 0000h, the status word reads 0000h, and `arb_req` and `irq` are 0.
- R2: In the control word, bit 15 (interrupt enable), bits 13:8 (byte count) and bits 2:1 (cycle kind) read back as last accepted. Bits 14 and 7:3 and the launch bit 0 always read 0.
- R3: An accepted control write with bit 0 set and kind 00 (read), 10 (write) or 11 (erase) drives `arb_req` high from the next cycle. The request uses the kind, count and enable carried in that same write. `arb_req` stays high until `arb_gnt` is sampled high.
- R4: `arb_req` is low in the cycle after `arb_gnt` is sampled high. From the grant until completion, `cyc_kind` and `cyc_cnt` do not change.
- R5: `cyc_cnt` equals bits 13:8 of the control word (bytes transferred minus one) for kinds 00 and 10, and is 0 for kind 11.
- R6: A `cyc_done` pulse sampled while a granted cycle runs sets status bit 0 in the next cycle. A `cyc_done` pulse while no cycle is granted has no effect.
- R7: `irq` equals status bit 0 ANDed with control bit 15.
- R8: Control writes are ignored from the launch until status bit 0 is cleared. A write of 1 to status bit 0 is accepted while the control word is locked.
- R9: A launch with kind 01 (reserved) raises no request and sets status bit 0 in the next cycle.
- R10: The done flag stays set until a status write with bit 0 equal to 1. A status write with bit 0 equal to 0 leaves it set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register word address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr` (combinational) |
| arb_req | output | 1 | Cycle request to the flash arbiter |
| arb_gnt | input | 1 | Grant from the flash arbiter |
| cyc_kind | output | 2 | Cycle kind presented to the serial engine |
| cyc_cnt | output | 6 | Byte count minus one presented to the engine (0 for erase) |
| cyc_done | input | 1 | Completion pulse from the serial engine |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with a 3-bit address and places the control and status words at addresses 2 and 5 instead of the defaults. This checks that decoding follows the parameters and not fixed offsets. It also writes to an unmapped address and checks that this write has no effect. Random control words cover all four cycle kinds, every byte count and both enable settings. Random grant and completion delays exercise the request hold and the write lock across cycles of different length.

// File: rtl/fsc_pkg.sv
package fsc_pkg;
  localparam int REG_W    = 16;
  localparam int GO_BIT   = 0;
  localparam int KIND_LSB = 1;
  localparam int KIND_W   = 2;
  localparam int CNT_LSB  = 8;
  localparam int CNT_W    = 6;
  localparam int IE_BIT   = 15;
  localparam int DONE_BIT = 0;

  typedef enum logic [KIND_W-1:0] {
    KIND_READ  = 2'b00,
    KIND_RSVD  = 2'b01,
    KIND_WRITE = 2'b10,
    KIND_ERASE = 2'b11
  } cyc_kind_e;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'b00,
    SQ_REQ  = 2'b01,
    SQ_BUSY = 2'b10
  } seq_state_e;
endpackage

// File: rtl/fsc_cfg_regs.sv
module fsc_cfg_regs
  import fsc_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int CTL_ADDR = 0
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en_i,
  input  logic [ADDR_W-1:0]      addr_i,
  input  logic [REG_W-1:0]       wdata_i,
  input  logic                   locked_i,
  output cyc_kind_e              kind_o,
  output logic [CNT_W-1:0]       cnt_o,
  output logic                   ie_o,
  output logic                   launch_o,
  output cyc_kind_e              launch_kind_o
);
  localparam logic [ADDR_W-1:0] CTL_SEL = ADDR_W'(CTL_ADDR);

  cyc_kind_e          kind_q, kind_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic               ie_q, ie_d;
  logic               accept;
  logic               unused_wbits;

  assign unused_wbits = ^{wdata_i[14], wdata_i[7:3]};
  assign accept = wr_en_i && (addr_i == CTL_SEL) && !locked_i;

  always_comb begin
    kind_d = kind_q;
    cnt_d  = cnt_q;
    ie_d   = ie_q;
    if (accept) begin
      kind_d = cyc_kind_e'(wdata_i[KIND_LSB +: KIND_W]);
      cnt_d  = wdata_i[CNT_LSB +: CNT_W];
      ie_d   = wdata_i[IE_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind_q <= KIND_READ;
      cnt_q  <= '0;
      ie_q   <= 1'b0;
    end else if (accept) begin
      kind_q <= kind_d;
      cnt_q  <= cnt_d;
      ie_q   <= ie_d;
    end
  end

  assign kind_o        = kind_q;
  assign cnt_o         = cnt_q;
  assign ie_o          = ie_q;
  assign launch_o      = accept && wdata_i[GO_BIT];
  assign launch_kind_o = cyc_kind_e'(wdata_i[KIND_LSB +: KIND_W]);

  // R8
  cfg_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    locked_i |=> ($stable(kind_q) && $stable(cnt_q) && $stable(ie_q)));
endmodule

// File: rtl/fsc_seq.sv
module fsc_seq
  import fsc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       launch_i,
  input  cyc_kind_e  launch_kind_i,
  input  logic       gnt_i,
  input  logic       cyc_done_i,
  input  logic       clr_done_i,
  output logic       req_o,
  output logic       busy_o,
  output logic       done_o,
  output logic       locked_o
);
  seq_state_e state_q, state_d;
  logic       done_q, done_d;
  logic       set_done;

  always_comb begin
    state_d  = state_q;
    set_done = 1'b0;
    case (state_q)
      SQ_IDLE: if (launch_i) begin
        if (launch_kind_i == KIND_RSVD) set_done = 1'b1;
        else                            state_d  = SQ_REQ;
      end
      SQ_REQ:  if (gnt_i) state_d = SQ_BUSY;
      SQ_BUSY: if (cyc_done_i) begin
        state_d  = SQ_IDLE;
        set_done = 1'b1;
      end
      default: state_d = SQ_IDLE;
    endcase
    done_d = done_q;
    if (set_done)        done_d = 1'b1;
    else if (clr_done_i) done_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
    end
  end

  assign req_o    = (state_q == SQ_REQ);
  assign busy_o   = (state_q == SQ_BUSY);
  assign done_o   = done_q;
  assign locked_o = (state_q != SQ_IDLE) || done_q;

  // R3
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_o && !gnt_i) |=> req_o);
  // R4
  req_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_o && gnt_i) |=> (!req_o && busy_o));
  // R10
  done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && !clr_done_i) |=> done_q);
  // R9
  rsvd_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (launch_i && !locked_o && launch_kind_i == KIND_RSVD) |=> (done_q && !req_o));
endmodule

// File: rtl/flash_seq_ctl.sv
module flash_seq_ctl
  import fsc_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int CTL_ADDR = 0,
  parameter int STS_ADDR = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [15:0]       reg_wdata,
  output logic [15:0]       reg_rdata,
  output logic              arb_req,
  input  logic              arb_gnt,
  output logic [1:0]        cyc_kind,
  output logic [5:0]        cyc_cnt,
  input  logic              cyc_done,
  output logic              irq
);
  localparam logic [ADDR_W-1:0] CTL_SEL = ADDR_W'(CTL_ADDR);
  localparam logic [ADDR_W-1:0] STS_SEL = ADDR_W'(STS_ADDR);

  cyc_kind_e        kind, launch_kind;
  logic [CNT_W-1:0] cnt;
  logic             ie, launch, locked, done, busy, clr_done;

  assign clr_done = reg_wr_en && (reg_addr == STS_SEL) && reg_wdata[DONE_BIT];

  fsc_cfg_regs #(.ADDR_W(ADDR_W), .CTL_ADDR(CTL_ADDR)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en_i(reg_wr_en), .addr_i(reg_addr),
    .wdata_i(reg_wdata), .locked_i(locked), .kind_o(kind), .cnt_o(cnt),
    .ie_o(ie), .launch_o(launch), .launch_kind_o(launch_kind)
  );

  fsc_seq u_seq (
    .clk(clk), .rst_n(rst_n), .launch_i(launch), .launch_kind_i(launch_kind),
    .gnt_i(arb_gnt), .cyc_done_i(cyc_done), .clr_done_i(clr_done),
    .req_o(arb_req), .busy_o(busy), .done_o(done), .locked_o(locked)
  );

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == CTL_SEL) begin
      reg_rdata[IE_BIT]                 = ie;
      reg_rdata[CNT_LSB +: CNT_W]       = cnt;
      reg_rdata[KIND_LSB +: KIND_W]     = kind;
    end else if (reg_addr == STS_SEL) begin
      reg_rdata[DONE_BIT]               = done;
    end
  end

  assign cyc_kind = kind;
  assign cyc_cnt  = (kind == KIND_ERASE) ? '0 : cnt;
  assign irq      = done && ie;

  // R4
  cyc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !cyc_done) |=> ($stable(cyc_kind) && $stable(cyc_cnt)));
  // R6
  done_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cyc_done) |=> (done && !busy));
  // R7
  irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (done && locked));
endmodule

// File: tb/flash_seq_ctl_tb.sv
module flash_seq_ctl_tb;
  localparam int AW  = 3;
  localparam int CTL = 2;
  localparam int STS = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr_en = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic arb_req, arb_gnt = 1'b0;
  logic [1:0] cyc_kind;
  logic [5:0] cyc_cnt;
  logic cyc_done = 1'b0;
  logic irq;

  int n_chk = 0, n_bad = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  flash_seq_ctl #(.ADDR_W(AW), .CTL_ADDR(CTL), .STS_ADDR(STS)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .arb_req(arb_req),
    .arb_gnt(arb_gnt), .cyc_kind(cyc_kind), .cyc_cnt(cyc_cnt),
    .cyc_done(cyc_done), .irq(irq)
  );

  function automatic logic [15:0] ctl_view(input logic [15:0] d);
    return d & 16'hBF06;
  endfunction

  function automatic logic [5:0] cnt_view(input logic [15:0] d);
    return (d[2:1] == 2'b11) ? 6'd0 : d[13:8];
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr_en = 1'b1;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [15:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    finish_run();
  end

  initial begin
    logic [15:0] v, cfg;
    void'($urandom(32'd20240611));
    #1;
    rd(CTL, v); check("R1 ctl at reset", v, 16'h0000);
    rd(STS, v); check("R1 status at reset", v, 16'h0000);
    check("R1 arb_req at reset", arb_req, 1'b0);
    check("R1 irq at reset", irq, 1'b0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;

    // Directed: all bits set without go, check readback mask
    wr(CTL, 16'hFFFE);
    rd(CTL, v); check("R2 readback all ones", v, 16'hBF06);
    check("R5 erase count zero", cyc_cnt, 6'd0);
    // Unmapped address write ignored
    wr(3'd0, 16'h0003);
    rd(CTL, v); check("R2 unmapped write ignored", v, 16'hBF06);
    check("R3 unmapped write no req", arb_req, 1'b0);
    // Done pulse while idle ignored
    @(negedge clk); cyc_done = 1'b1; @(negedge clk); cyc_done = 1'b0;
    rd(STS, v); check("R6 idle done ignored", v, 16'h0000);

    for (int i = 0; i < 40; i++) begin
      cfg = 16'($urandom());
      if (i < 4) cfg[2:1] = 2'(i);
      cfg[0] = 1'b0;
      wr(CTL, cfg);
      rd(CTL, v); check("R2 readback", v, ctl_view(cfg));
      cfg = 16'($urandom());
      if (i < 4) cfg[2:1] = 2'(3 - i);
      cfg[0] = 1'b1;
      wr(CTL, cfg);
      rd(CTL, v); check("R2 go reads 0, same-write capture", v, ctl_view(cfg));
      if (cfg[2:1] == 2'b01) begin
        check("R9 reserved no req", arb_req, 1'b0);
        rd(STS, v); check("R9 reserved sets done", v, 16'h0001);
      end else begin
        check("R3 req raised", arb_req, 1'b1);
        check("R3 kind", cyc_kind, cfg[2:1]);
        check("R5 count", cyc_cnt, cnt_view(cfg));
        wr(CTL, ~cfg);
        rd(CTL, v); check("R8 locked while requesting", v, ctl_view(cfg));
        for (int w = 0; w < int'($urandom_range(0, 3)); w++) begin
          @(negedge clk);
          check("R3 req held", arb_req, 1'b1);
        end
        @(negedge clk); arb_gnt = 1'b1;
        @(negedge clk); arb_gnt = 1'b0;
        check("R4 req dropped after grant", arb_req, 1'b0);
        wr(CTL, 16'h0000);
        repeat ($urandom_range(0, 4)) @(negedge clk);
        check("R4 kind held", cyc_kind, cfg[2:1]);
        check("R4 count held", cyc_cnt, cnt_view(cfg));
        rd(CTL, v); check("R8 locked while busy", v, ctl_view(cfg));
        rd(STS, v); check("R6 done clear before completion", v, 16'h0000);
        cyc_done = 1'b1; @(negedge clk); cyc_done = 1'b0;
        rd(STS, v); check("R6 done set", v, 16'h0001);
      end
      check("R7 irq", irq, cfg[15]);
      wr(CTL, ~cfg);
      rd(CTL, v); check("R8 locked while done", v, ctl_view(cfg));
      wr(STS, 16'hFFFE);
      rd(STS, v); check("R10 zero write keeps done", v, 16'h0001);
      wr(STS, 16'h0001);
      rd(STS, v); check("R8 clear accepted", v, 16'h0000);
      check("R7 irq low after clear", irq, 1'b0);
      check("R8 no req after clear", arb_req, 1'b0);
    end
    finish_run();
  end
endmodule